// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator value after a binary add or subtract of two packed-BCD operands, so that the byte again holds two valid decimal digits. It takes the raw accumulator byte and three incoming condition flags: the subtract marker N, the half-carry H and the carry C. From these it decides whether each nibble needs a correction of six. It then adds the correction when the previous operation was an addition and subtracts it when it was a subtraction.

The unit samples its inputs when `in_valid` is high and presents the corrected byte and a full flag byte on registered outputs one clock later. The correction is worked out from magnitude comparisons and flag tests rather than from a lookup table. Outputs hold their last value while no new sample is presented.

Top module: `bcd_adj_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `acc_out` and `flags_out` to zero.
- R2: A sample taken on a rising edge with `in_valid` high appears on `acc_out`/`flags_out` after that edge, and `out_valid` is high for exactly the cycles following a sampling edge.
- R3: With N=0, 0x06 is added when the low nibble of the input byte is above 9 or H is 1.
- R4: With N=0, 0x60 is added when the whole input byte is above 0x99 or C is 1; this test uses the byte before any low-nibble correction.
- R5: With N=1, the same two conditions select the same constants, and they are subtracted modulo 256 instead of added.
- R6: Output C is 1 exactly when the 0x60 correction was applied, so an incoming C of 1 always gives an outgoing C of 1.
- R7: Output H is the carry (N=0) or borrow (N=1) out of bit 3 of the low nibble when the low correction (0x06 or 0x00) is applied to it.
- R8: Output P/V is 1 when the adjusted byte has an even number of set bits.
- R9: The flag byte places S at bit 7, Z at bit 6, Y at bit 5, H at bit 4, X at bit 3, P/V at bit 2, N at bit 1 and C at bit 0. S, Y and X copy bits 7, 5 and 3 of the adjusted byte, and Z is 1 when it is zero.
- R10: Output N equals the sampled N input.
- R11: While `in_valid` is low, `acc_out` and `flags_out` keep their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample the data inputs on this edge |
| acc_in | input | 8 | Accumulator byte to be adjusted |
| n_in | input | 1 | Subtract marker of the previous operation |
| h_in | input | 1 | Incoming half-carry |
| c_in | input | 1 | Incoming carry |
| out_valid | output | 1 | Registered result is fresh |
| acc_out | output | 8 | Adjusted accumulator byte |
| flags_out | output | 8 | Flags S,Z,Y,H,X,P/V,N,C from bit 7 down to bit 0 |

## Verification
The bench targets the nibble boundaries 9/10 and the byte boundary 0x99/0x9A. A design that tests the high digit after the low correction, or that uses "at least" where "above" is meant, would add 0x60 to 0x99 or miss it on 0x9A. Subtraction cases with a borrow out of the low nibble, and wraps past zero, expose a unit that always adds or that derives H from the wrong step. An exhaustive sweep over every byte and flag combination catches parity inversion, flags in the wrong bit positions and a carry that drops an incoming C.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned DIGITS   = 2;
  localparam int unsigned BYTE_W   = DIGIT_W * DIGITS;
  localparam int unsigned DIGIT_MAX = 9;

  localparam logic [DIGIT_W-1:0] LO_LIMIT = DIGIT_W'(DIGIT_MAX);
  localparam logic [BYTE_W-1:0]  HI_LIMIT = {LO_LIMIT, LO_LIMIT};
  localparam logic [DIGIT_W-1:0] STEP     = DIGIT_W'(6);

  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic p;
    logic n;
    logic c;
  } flag_byte_t;

  typedef struct packed {
    logic lo_fix;
    logic hi_fix;
  } fix_sel_t;

endpackage

// File: rtl/bcd_adj_detect.sv
module bcd_adj_detect
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] acc,
  input  logic              h_in,
  input  logic              c_in,
  output fix_sel_t          sel
);

  logic lo_over;
  logic hi_over;

  always_comb begin
    lo_over    = acc[DIGIT_W-1:0] > LO_LIMIT;
    hi_over    = acc > HI_LIMIT;
    sel.lo_fix = lo_over | h_in;
    sel.hi_fix = hi_over | c_in;
  end

endmodule

// File: rtl/bcd_adj_apply.sv
module bcd_adj_apply
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] acc,
  input  logic              sub,
  input  fix_sel_t          sel,
  output logic [BYTE_W-1:0] result,
  output logic              half
);

  logic [BYTE_W-1:0]  corr;
  logic [DIGIT_W:0]   lo_step;
  logic [DIGIT_W:0]   lo_ext;
  logic [DIGIT_W:0]   lo_corr_ext;

  always_comb begin
    corr[DIGIT_W-1:0]      = sel.lo_fix ? STEP : '0;
    corr[BYTE_W-1:DIGIT_W] = sel.hi_fix ? STEP : '0;
    lo_ext      = {1'b0, acc[DIGIT_W-1:0]};
    lo_corr_ext = {1'b0, corr[DIGIT_W-1:0]};
    if (sub) begin
      lo_step = lo_ext - lo_corr_ext;
      result  = acc - corr;
    end else begin
      lo_step = lo_ext + lo_corr_ext;
      result  = acc + corr;
    end
    half = lo_step[DIGIT_W];
  end

endmodule

// File: rtl/bcd_adj_flags.sv
module bcd_adj_flags
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] result,
  input  logic              half,
  input  logic              sub,
  input  fix_sel_t          sel,
  output flag_byte_t        flags
);

  always_comb begin
    flags.s = result[BYTE_W-1];
    flags.z = (result == '0);
    flags.y = result[5];
    flags.h = half;
    flags.x = result[3];
    flags.p = ~(^result);
    flags.n = sub;
    flags.c = sel.hi_fix;
  end

endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit
  import bcd_adj_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  acc_in,
  input  logic        n_in,
  input  logic        h_in,
  input  logic        c_in,
  output logic        out_valid,
  output logic [7:0]  acc_out,
  output logic [7:0]  flags_out
);

  fix_sel_t          sel;
  logic [BYTE_W-1:0] adj;
  logic              half;
  flag_byte_t        flg;

  bcd_adj_detect u_detect (
    .acc  (acc_in),
    .h_in (h_in),
    .c_in (c_in),
    .sel  (sel)
  );

  bcd_adj_apply u_apply (
    .acc    (acc_in),
    .sub    (n_in),
    .sel    (sel),
    .result (adj),
    .half   (half)
  );

  bcd_adj_flags u_flags (
    .result (adj),
    .half   (half),
    .sub    (n_in),
    .sel    (sel),
    .flags  (flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out   <= adj;
        flags_out <= flg;
      end
    end
  end

endmodule

// File: rtl/bcd_adj_unit_chk.sv
module bcd_adj_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] acc_in,
  input logic       n_in,
  input logic       h_in,
  input logic       c_in,
  input logic       out_valid,
  input logic [7:0] acc_out,
  input logic [7:0] flags_out
);

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && acc_out == 8'h00 && flags_out == 8'h00));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  a_r6_carry_sticky: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_in) |=> flags_out[0]);

  a_r6_no_high_fix: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !c_in && acc_in <= 8'h99) |=> !flags_out[0]);

  a_r10_n_passes: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flags_out[1] == $past(n_in));

  a_r5_plain_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !h_in && !c_in && acc_in[3:0] <= 4'h9 && acc_in[7:4] <= 4'h9)
      |=> acc_out == $past(acc_in));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_out) && $stable(flags_out)));

endmodule

bind bcd_adj_unit bcd_adj_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .acc_in    (acc_in),
  .n_in      (n_in),
  .h_in      (h_in),
  .c_in      (c_in),
  .out_valid (out_valid),
  .acc_out   (acc_out),
  .flags_out (flags_out)
);

// File: tb/bcd_adj_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_adj_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] acc_in;
  logic       n_in;
  logic       h_in;
  logic       c_in;
  logic       out_valid;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_adj_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .acc_in    (acc_in),
    .n_in      (n_in),
    .h_in      (h_in),
    .c_in      (c_in),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // {acc, n, h, c, expected acc, expected flags S Z Y H X P N C}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {8'h15, 1'b0, 1'b0, 1'b0, 8'h15, 8'h00},  // R3 R4 no correction
    {8'h0F, 1'b0, 1'b0, 1'b0, 8'h15, 8'h10},  // R3 R7 low digit over 9
    {8'h9A, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55},  // R4 R6 byte above 0x99
    {8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h45},  // R4 R9 zero result
    {8'h12, 1'b0, 1'b1, 1'b0, 8'h18, 8'h0C},  // R3 H forces low fix
    {8'h23, 1'b0, 1'b0, 1'b1, 8'h83, 8'h81},  // R6 carry forces high fix
    {8'h0F, 1'b1, 1'b1, 1'b0, 8'h09, 8'h0E},  // R5 subtract low fix
    {8'hF0, 1'b1, 1'b0, 1'b1, 8'h90, 8'h87},  // R5 subtract high fix
    {8'h02, 1'b1, 1'b1, 1'b1, 8'h9C, 8'h9F},  // R5 R7 wrap with borrow
    {8'h99, 1'b0, 1'b0, 1'b0, 8'h99, 8'h8C},  // R4 boundary 0x99
    {8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h46},  // R10 R8 zero subtract
    {8'h3C, 1'b0, 1'b0, 1'b0, 8'h42, 8'h14}   // R3 R8 low digit 0xC
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic n, input logic h, input logic c);
    @(negedge clk);
    acc_in = a; n_in = n; h_in = h; c_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] model(input int a, input bit n, input bit h, input bit c);
    bit lo_need, hi_need, hh;
    int delta, r;
    logic [7:0] rb, fb;
    lo_need = ((a % 16) > 9) || h;
    hi_need = (a > 153) || c;
    delta   = (hi_need ? 96 : 0) + (lo_need ? 6 : 0);
    r       = n ? ((a + 256 - delta) % 256) : ((a + delta) % 256);
    hh      = n ? (lo_need && (a % 16) < 6) : (lo_need && (a % 16) > 9);
    rb      = r[7:0];
    fb      = {rb[7], (r == 0), rb[5], hh, rb[3], ($countones(rb) % 2 == 0), n, hi_need};
    return {rb, fb};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; acc_in = 8'h5A; n_in = 1'b1; h_in = 1'b1; c_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 acc", acc_out, 8'h00);
    check("R1 flags", flags_out, 8'h00);
    check("R1 valid", {7'd0, out_valid}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][26:19], VEC[i][18], VEC[i][17], VEC[i][16]);
      check("R2 valid", {7'd0, out_valid}, 8'h01);
      check("R3-R5 acc", acc_out, VEC[i][15:8]);
      check("R6-R10 flags", flags_out, VEC[i][7:0]);
    end

    // R11: inputs move while in_valid is low
    apply(8'h3C, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    acc_in = 8'hFF; n_in = 1'b1; h_in = 1'b1; c_in = 1'b1;
    @(negedge clk);
    check("R11 hold acc", acc_out, 8'h42);
    check("R11 hold flags", flags_out, 8'h14);
    check("R2 valid low", {7'd0, out_valid}, 8'h00);

    // R1: mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid acc", acc_out, 8'h00);
    check("R1 mid flags", flags_out, 8'h00);

    // R3..R10 exhaustive sweep against the requirement model
    for (int a = 0; a < 256; a++) begin
      for (int f = 0; f < 8; f++) begin
        logic [15:0] e;
        e = model(a, f[2], f[1], f[0]);
        apply(a[7:0], f[2], f[1], f[0]);
        check("R3-R7 sweep acc", acc_out, e[15:8]);
        check("R6-R10 sweep flags", flags_out, e[7:0]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule